// File: doc/BRIEF.md
# Hierarchical Vertical-Crosswise Multiplier

This block multiplies two unsigned operands and produces the full double-width product. It does not use shift-and-add. The work splits recursively: each operand is cut into a low half and a high half, and the four half-width cross products are formed side by side. Those products are then merged with ripple adders. The recursion ends in a 2x2 cell. Every part of the datapath is a composition of reversible gates: the leaf cells are built from Peres gates, the adders from HNG gates, and the carry merge uses a Feynman gate. The constant inputs and the discarded gate outputs stay as internal wires.

Set to its defaults, the block is an 8x8 multiplier with a 16-bit result. An optional output register is chosen by a parameter. With the register, the product of the operands sampled at one rising edge is available after that edge and holds until the next. Without the register, the block is purely combinational. An elaboration check rejects any operand width that is not a power of two of at least 2.

Top module: `vcmul_top`

## Requirements
- R1: For every pair of unsigned operands, `prod` equals `op_a * op_b` as a 2W-bit unsigned value (all 65536 pairs at W=8).
- R2: When either operand is zero, the product is zero.
- R3: When one operand equals 1, the product equals the other operand, zero-extended.
- R4: When both operands are all ones, the product is (2^W-1)^2. At W=8 this is 16'hFE01.
- R5: When both operands are below 2^(W/2), the upper W bits of the product are zero.
- R6: With OUT_REG=1, `prod` is cleared to zero while `rst_n` is low, independent of the clock. After reset, `prod` shows the product of the operands sampled at the most recent rising edge, exactly one clock after they are presented, and it does not follow operand changes between edges. With OUT_REG=0, `prod` follows the operands with no clock.
- R7: At W=2 the leaf cell gives p[0]=a0·b0, p[1]=(a1·b0) XOR (a0·b1), p[2]=(a0·a1·b0·b1) XOR (a1·b1), and p[3]=a0·a1·b0·b1, where a0 and b0 are bit 0 of the operands.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Active-low asynchronous reset of the output register |
| op_a | input | W | Unsigned multiplicand |
| op_b | input | W | Unsigned multiplier |
| prod | output | 2*W | Unsigned product |

## Verification
The checker compares the product with operands it samples at each rising edge. It therefore assumes the operands are stable around that edge and contain no X or Z bits. The stimulus changes the operands only on falling edges and always drives defined values.

In the registered build, the checker keeps its own copy of the previous operands. It stays disarmed until one edge after reset is released, so the reset value is never compared against a product.

// File: rtl/vcmul_pkg.sv
package vcmul_pkg;

   // legal operand width: power of two, at least 2
   function automatic bit width_ok(input int unsigned w);
      return (w >= 2) && ((w & (w - 1)) == 0);
   endfunction

endpackage

// File: rtl/rev_gates.sv
// Peres: (a,b,c) -> (a, a^b, (a&b)^c)
module rev_peres (
   input  logic a,
   input  logic b,
   input  logic c,
   output logic p,
   output logic q,
   output logic r
);
   assign p = a;
   assign q = a ^ b;
   assign r = (a & b) ^ c;
endmodule

// Feynman / CNOT: (a,b) -> (a, a^b)
module rev_feynman (
   input  logic a,
   input  logic b,
   output logic p,
   output logic q
);
   assign p = a;
   assign q = a ^ b;
endmodule

// HNG: (a,b,c,d) -> (a, b, a^b^c, ((a^b)&c)^(a&b)^d)
module rev_hng (
   input  logic a,
   input  logic b,
   input  logic c,
   input  logic d,
   output logic p,
   output logic q,
   output logic r,
   output logic s
);
   assign p = a;
   assign q = b;
   assign r = a ^ b ^ c;
   assign s = ((a ^ b) & c) ^ (a & b) ^ d;
endmodule

// File: rtl/hng_rca.sv
// Ripple-carry adder: one HNG gate per bit, constant input tied low
module hng_rca #(
   parameter int unsigned W = 4
) (
   input  logic [W-1:0] x,
   input  logic [W-1:0] y,
   input  logic         cin,
   output logic [W-1:0] sum,
   output logic         cout
);
   logic [W:0]   cy;
   logic [W-1:0] unused_pa;
   logic [W-1:0] unused_pb;

   assign cy[0] = cin;

   for (genvar i = 0; i < W; i++) begin : g_bit
      rev_hng u_fa (
         .a(x[i]), .b(y[i]), .c(cy[i]), .d(1'b0),
         .p(unused_pa[i]), .q(unused_pb[i]),
         .r(sum[i]), .s(cy[i+1])
      );
   end

   assign cout = cy[W];
endmodule

// File: rtl/vc_leaf.sv
// 2x2 cell from Peres gates: four constant inputs, nine garbage outputs
module vc_leaf (
   input  logic [1:0] a,
   input  logic [1:0] b,
   output logic [3:0] q
);
   logic x_cross, y_cross, all4;
   logic unused_g0, unused_g1, unused_g2, unused_g3, unused_g4;
   logic unused_g5, unused_g6, unused_g7, unused_g8;

   rev_peres u_ll (.a(a[0]), .b(b[0]), .c(1'b0),
                   .p(unused_g0), .q(unused_g1), .r(q[0]));
   rev_peres u_hl (.a(a[1]), .b(b[0]), .c(1'b0),
                   .p(unused_g2), .q(unused_g3), .r(x_cross));
   rev_peres u_lh (.a(a[0]), .b(b[1]), .c(1'b0),
                   .p(unused_g4), .q(unused_g5), .r(y_cross));
   // cross terms: xor gives bit 1, and gives the four-way product
   rev_peres u_mx (.a(x_cross), .b(y_cross), .c(1'b0),
                   .p(unused_g6), .q(q[1]), .r(all4));
   // high term folded with the four-way product
   rev_peres u_hh (.a(a[1]), .b(b[1]), .c(all4),
                   .p(unused_g7), .q(unused_g8), .r(q[2]));

   assign q[3] = all4;
endmodule

// File: rtl/vc_unit.sv
// NxN unit: recursive split into four half-width products
module vc_unit #(
   parameter int unsigned N = 8
) (
   input  logic [N-1:0]   a,
   input  logic [N-1:0]   b,
   output logic [2*N-1:0] p
);
   if (N == 2) begin : g_leaf
      vc_leaf u_leaf (.a(a), .b(b), .q(p));
   end else begin : g_split
      localparam int unsigned H = N / 2;

      logic [N-1:0] ll, lh, hl, hh;
      logic [N-1:0] s1, s2, hi_add, top;
      logic         c1, c2, cmid;
      logic         unused_fy, unused_top_co;

      // all four sub-products in parallel
      vc_unit #(.N(H)) u_ll (.a(a[H-1:0]), .b(b[H-1:0]), .p(ll));
      vc_unit #(.N(H)) u_lh (.a(a[H-1:0]), .b(b[N-1:H]), .p(lh));
      vc_unit #(.N(H)) u_hl (.a(a[N-1:H]), .b(b[H-1:0]), .p(hl));
      vc_unit #(.N(H)) u_hh (.a(a[N-1:H]), .b(b[N-1:H]), .p(hh));

      // middle column: cross products plus upper half of ll
      hng_rca #(.W(N)) u_mid0 (.x(lh), .y(hl), .cin(1'b0),
                               .sum(s1), .cout(c1));
      hng_rca #(.W(N)) u_mid1 (.x(s1), .y(N'(ll[N-1:H])), .cin(1'b0),
                               .sum(s2), .cout(c2));

      // middle total stays below 2^(N+1): c1 and c2 never both set
      rev_feynman u_cm (.a(c1), .b(c2), .p(unused_fy), .q(cmid));

      assign hi_add = N'({cmid, s2[N-1:H]});

      hng_rca #(.W(N)) u_top (.x(hh), .y(hi_add), .cin(1'b0),
                              .sum(top), .cout(unused_top_co));

      assign p = {top, s2[H-1:0], ll[H-1:0]};
   end
endmodule

// File: rtl/vcmul_top.sv
module vcmul_top #(
   parameter int unsigned W       = 8,
   parameter bit          OUT_REG = 1'b1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [W-1:0]   op_a,
   input  logic [W-1:0]   op_b,
   output logic [2*W-1:0] prod
);
   localparam int unsigned PW = 2 * W;

   if (!vcmul_pkg::width_ok(W)) begin : g_bad_width
      $error("vcmul_top: W must be a power of two and at least 2");
   end

   logic [PW-1:0] raw;

   vc_unit #(.N(W)) u_core (.a(op_a), .b(op_b), .p(raw));

   if (OUT_REG) begin : g_reg
      logic [PW-1:0] prod_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) prod_q <= '0;
         else        prod_q <= raw;
      end
      assign prod = prod_q;
   end else begin : g_comb
      assign prod = raw;
   end
endmodule

// File: rtl/vcmul_chk.sv
module vcmul_chk #(
   parameter int unsigned W       = 8,
   parameter bit          OUT_REG = 1'b1
) (
   input logic           clk,
   input logic           rst_n,
   input logic [W-1:0]   op_a,
   input logic [W-1:0]   op_b,
   input logic [2*W-1:0] prod
);
   localparam int unsigned  PW     = 2 * W;
   localparam logic [W-1:0] NARROW = W'(1) << (W / 2);
   localparam logic [PW-1:0] ONES_SQ =
      {{(W-1){1'b1}}, 1'b0, {(W-1){1'b0}}, 1'b1};

   logic         armed;
   logic [W-1:0] ea, eb;

   if (OUT_REG) begin : g_lag
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            armed <= 1'b0;
            ea    <= '0;
            eb    <= '0;
         end else begin
            armed <= 1'b1;
            ea    <= op_a;
            eb    <= op_b;
         end
      end
   end else begin : g_now
      assign armed = rst_n;
      assign ea    = op_a;
      assign eb    = op_b;
   end

   // R1 R6
   product_chk: assert property (@(posedge clk) disable iff (!rst_n)
      armed |-> prod == PW'(ea) * PW'(eb));
   // R2
   zero_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && (ea == '0 || eb == '0)) |-> prod == '0);
   // R3
   unit_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && ea == W'(1)) |-> prod == PW'(eb));
   // R4
   all_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && (&ea) && (&eb)) |-> prod == ONES_SQ);
   // R5
   narrow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && ea < NARROW && eb < NARROW) |-> prod[PW-1:W] == '0);
endmodule

bind vcmul_top vcmul_chk #(.W(W), .OUT_REG(OUT_REG)) u_chk (
   .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .prod(prod)
);

// File: tb/sim_vcmul_top.sv
`timescale 1ns/1ps
module sim_vcmul_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  a = '0, b = '0;
   logic [1:0]  a2 = '0, b2 = '0;
   logic [15:0] p_reg, p_comb;
   logic [3:0]  p_leaf;

   int errors = 0;
   int checks = 0;
   int exp_q[$];

   always #2.5 clk = ~clk;

   vcmul_top #(.W(8), .OUT_REG(1'b1)) u0 (
      .clk(clk), .rst_n(rst_n), .op_a(a), .op_b(b), .prod(p_reg));
   vcmul_top #(.W(8), .OUT_REG(1'b0)) u1 (
      .clk(clk), .rst_n(rst_n), .op_a(a), .op_b(b), .prod(p_comb));
   vcmul_top #(.W(2), .OUT_REG(1'b0)) u2 (
      .clk(clk), .rst_n(rst_n), .op_a(a2), .op_b(b2), .prod(p_leaf));

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic string tag(input int x, input int y);
      if (x == 0 || y == 0)         return "R2";
      if (x == 1 || y == 1)         return "R3";
      if (x == 255 && y == 255)     return "R4";
      if (x < 16 && y < 16)         return "R5";
      return "R1";
   endfunction

   initial begin
      #1000000;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      // reset: registered output cleared, comb output follows inputs
      a = 8'd37; b = 8'd11;
      repeat (3) @(negedge clk);
      chk("R6 reset", int'(p_reg), 0);
      chk("R6 comb", int'(p_comb), 37 * 11);
      a = 8'd0; b = 8'd0;
      rst_n = 1'b1;

      // exhaustive sweep, reference model as a queue
      for (int i = 0; i < 65536; i++) begin
         @(negedge clk);
         if (exp_q.size() > 0) chk("R1 R6 reg", int'(p_reg), exp_q.pop_front());
         a = 8'(i >> 8);
         b = 8'(i);
         exp_q.push_back(int'(a) * int'(b));
         #1;
         chk(tag(int'(a), int'(b)), int'(p_comb), int'(a) * int'(b));
      end
      @(negedge clk);
      chk("R1 R6 reg last", int'(p_reg), exp_q.pop_front());

      // R6: register holds between edges, then updates one clock later
      a = 8'hFF; b = 8'hFF;
      #1;
      chk("R6 hold", int'(p_reg), 255 * 255);
      a = 8'd3; b = 8'd5;
      #1;
      chk("R6 hold2", int'(p_reg), 255 * 255);
      @(negedge clk);
      chk("R6 one-clock", int'(p_reg), 15);
      // R6: asynchronous clear mid-run
      rst_n = 1'b0;
      #1;
      chk("R6 async clear", int'(p_reg), 0);
      @(negedge clk);
      rst_n = 1'b1;
      a = 8'hFF; b = 8'hFF;
      @(negedge clk);
      chk("R4 reg FE01", int'(p_reg), 16'hFE01);

      // R7: leaf cell bit equations
      for (int i = 0; i < 16; i++) begin
         @(negedge clk);
         a2 = 2'(i >> 2);
         b2 = 2'(i);
         #1;
         begin
            logic t0, t1, t2, t3;
            t0 = a2[0] & b2[0];
            t1 = (a2[1] & b2[0]) ^ (a2[0] & b2[1]);
            t3 = a2[0] & a2[1] & b2[0] & b2[1];
            t2 = t3 ^ (a2[1] & b2[1]);
            chk("R7 leaf", int'(p_leaf), int'({t3, t2, t1, t0}));
         end
      end

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule